// File: doc/BRIEF.md
# Dual-Protocol Serial NOR Flash Responder

This block plays the device side of a serial NOR flash link. It watches chip select, the serial clock and four bidirectional data lines, and answers identification and read commands from a small read-only array. The array contents are computed from the byte address. The host side is assumed to use clock mode 0: the idle clock is low, the device samples on the rising edge and drives on the falling edge. All pins are oversampled by a faster system clock and are assumed to be already synchronized to it.

The responder has two interface personalities, selected by one volatile bit. In extended mode the opcode is always taken on a single line, and the opcode decides how wide the address and the data are. In quad mode every phase of every command moves four bits per clock. In this mode, opcodes that normally name single-line-command reads are executed as full four-line fast reads, and the set of identification opcodes the device answers changes. A boot input picks the mode that reset loads, so a host may find the device in either personality. A configuration command rewrites the bit, and the change takes effect when chip select rises.

Top module: `flash_mode_responder`

## Requirements
- R1: While reset is low the mode bit loads from `boot_quad` (1 = quad). After reset all data-line enables are 0.
- R2: In extended mode, opcode 0x9F (taken MSB first on line 0) returns the bytes 0x5E, 0x71, 0x18 MSB first on line 1, repeating in that order; opcode 0xAF is ignored.
- R3: In quad mode, opcode 0xAF (sent as two nibbles, high nibble first, line 3 = MSB) returns the same three bytes as nibbles on all four lines; opcode 0x9F is ignored.
- R4: Opcode 0x03 in extended mode takes a 24-bit address MSB first on line 0, adds no dummy clocks and returns bytes on line 1. The byte at address a is (a mod 256) XOR 0x3C, and the address increments by one per byte and wraps within 256 bytes.
- R5: Opcode 0x0B in extended mode behaves as 0x03, with 8 dummy clocks inserted between address and data.
- R6: In extended mode, 0x6B takes a single-line address and 0xEB takes a four-line address (6 nibbles). Both insert 8 dummy clocks and return data as nibbles on four lines, high nibble first, with line 3 the MSB.
- R7: In quad mode the opcode, address and data of every command use four lines. 0x03 adds no dummy clocks; 0x0B, 0x6B and 0xEB each add 8.
- R8: Opcode 0xB1 followed by one byte, both at the current command width, loads the mode bit from bit 7 of that byte. The new mode applies only after chip select rises. If chip select rises before the byte is complete, the mode is unchanged.
- R9: An unrecognised opcode causes no output until chip select goes high. The next selected transaction decodes normally.
- R10: The data-line enables are non-zero only during a data-out phase: 0b0010 for single-line data and 0b1111 for four-line data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_quad | input | 1 | Mode loaded during reset: 1 quad, 0 extended |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idle low |
| dq_in | input | 4 | Sampled data lines; line 0 carries single-line input |
| dq_out | output | 4 | Values the device places on the data lines |
| dq_oe | output | 4 | Per-line output enable |

## Verification
The hardest situation to reach is a mode change in which the old mode must stay in force until chip select rises, including the case where chip select rises in the middle of the configuration byte. The bench reaches it from the ports alone: it sends the configuration command at the current width, releases chip select early or on time, and then probes with both identification opcodes, since exactly one of them is answered in each mode. Four-line address reads that cross the top of the 256-byte array also need a precise address and dummy count before the wrap can be observed. These reads are driven from the vector table.

// File: rtl/flashresp_pkg.sv
package flashresp_pkg;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_CFG, PH_SKIP
  } phase_e;

  // decoded command attributes, latched once the opcode is complete
  typedef struct packed {
    logic is_read;
    logic is_id;
    logic is_cfg;
    logic addr_w4;
    logic data_w4;
    logic dummy;
  } cmd_t;

  // array content: a pure function of the byte index
  function automatic logic [7:0] fill_byte(input logic [15:0] idx);
    return idx[7:0] ^ idx[15:8] ^ 8'h3C;
  endfunction

endpackage

// File: rtl/fr_edge.sv
module fr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);
  logic sck_q, cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  assign sck_rise = sck & ~sck_q & ~cs_n;
  assign sck_fall = ~sck & sck_q & ~cs_n;
  assign cs_rise  = cs_n & ~cs_q;
endmodule

// File: rtl/fr_decode.sv
module fr_decode
  import flashresp_pkg::*;
#(
  parameter logic [7:0] CFG_OP = 8'hB1
) (
  input  logic [7:0] op,
  input  logic       quad,
  output cmd_t       cmd
);
  always_comb begin
    cmd = '0;
    if (op == CFG_OP) begin
      cmd.is_cfg = 1'b1;
    end else begin
      unique case (op)
        8'h03: begin
          cmd.is_read = 1'b1; cmd.addr_w4 = quad; cmd.data_w4 = quad;
        end
        8'h0B: begin
          cmd.is_read = 1'b1; cmd.addr_w4 = quad; cmd.data_w4 = quad;
          cmd.dummy = 1'b1;
        end
        8'h6B: begin
          cmd.is_read = 1'b1; cmd.addr_w4 = quad; cmd.data_w4 = 1'b1;
          cmd.dummy = 1'b1;
        end
        8'hEB: begin
          cmd.is_read = 1'b1; cmd.addr_w4 = 1'b1; cmd.data_w4 = 1'b1;
          cmd.dummy = 1'b1;
        end
        8'h9F: begin
          cmd.is_id = ~quad; cmd.data_w4 = 1'b0;
        end
        8'hAF: begin
          cmd.is_id = quad; cmd.data_w4 = 1'b1;
        end
        default: cmd = '0;
      endcase
    end
  end
endmodule

// File: rtl/fr_shiftout.sv
module fr_shiftout (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       shift,
  input  logic       w4,
  input  logic [7:0] byte_in,
  output logic       load,
  output logic [3:0] drive,
  output logic       active
);
  logic [2:0] rem;
  logic [7:0] sr;

  assign load = shift & (rem == 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem    <= '0;
      sr     <= '0;
      drive  <= '0;
      active <= 1'b0;
    end else if (clear) begin
      rem    <= '0;
      active <= 1'b0;
    end else if (shift) begin
      active <= 1'b1;
      if (rem == 3'd0) begin
        drive <= w4 ? byte_in[7:4] : {2'b00, byte_in[7], 1'b0};
        sr    <= w4 ? {byte_in[3:0], 4'b0000} : {byte_in[6:0], 1'b0};
        rem   <= w4 ? 3'd4 : 3'd7;
      end else begin
        drive <= w4 ? sr[7:4] : {2'b00, sr[7], 1'b0};
        sr    <= w4 ? {sr[3:0], 4'b0000} : {sr[6:0], 1'b0};
        rem   <= rem - (w4 ? 3'd4 : 3'd1);
      end
    end
  end
endmodule

// File: rtl/flash_mode_responder.sv
module flash_mode_responder
  import flashresp_pkg::*;
#(
  parameter int         ADDR_BITS  = 24,
  parameter int         MEM_AW     = 8,
  parameter int         DUMMY_CLKS = 8,
  parameter logic [7:0] CFG_OP     = 8'hB1,
  parameter logic [7:0] MFR_ID     = 8'h5E,
  parameter logic [7:0] TYPE_ID    = 8'h71,
  parameter logic [7:0] CAP_ID     = 8'h18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_quad,
  input  logic       cs_n,
  input  logic       sck,
  input  logic [3:0] dq_in,
  output logic [3:0] dq_out,
  output logic [3:0] dq_oe
);
  localparam int CNT_MAX = (ADDR_BITS > DUMMY_CLKS) ? ADDR_BITS : DUMMY_CLKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 4) + 1;

  phase_e               phase;
  logic [CNT_W-1:0]     cnt, cnt_next, step;
  logic [ADDR_BITS-1:0] sr_in, sr_next;
  logic [MEM_AW-1:0]    addr_q;
  logic                 quad_q, pend_v, pend_bit;
  cmd_t                 dec_q, dec_now;
  logic                 sck_rise, sck_fall, cs_rise;
  logic                 in_w4, ph_data, shift_out, load, active;
  logic [7:0]           byte_src, id_byte;
  logic [3:0]           drive;

  fr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
  );

  assign in_w4    = (phase == PH_ADDR) ? dec_q.addr_w4 : quad_q;
  assign step     = in_w4 ? CNT_W'(4) : CNT_W'(1);
  assign cnt_next = cnt + step;
  assign sr_next  = in_w4 ? {sr_in[ADDR_BITS-5:0], dq_in}
                          : {sr_in[ADDR_BITS-2:0], dq_in[0]};

  fr_decode #(.CFG_OP(CFG_OP)) u_dec (
    .op(sr_next[7:0]), .quad(quad_q), .cmd(dec_now)
  );

  always_comb begin
    unique case (addr_q[1:0])
      2'd0:    id_byte = MFR_ID;
      2'd1:    id_byte = TYPE_ID;
      default: id_byte = CAP_ID;
    endcase
  end
  assign byte_src  = dec_q.is_id ? id_byte : fill_byte(16'(addr_q));
  assign ph_data   = (phase == PH_DATA);
  assign shift_out = sck_fall & ph_data;

  fr_shiftout u_out (
    .clk(clk), .rst_n(rst_n), .clear(cs_n | ~ph_data), .shift(shift_out),
    .w4(dec_q.data_w4), .byte_in(byte_src),
    .load(load), .drive(drive), .active(active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quad_q   <= boot_quad;
      phase    <= PH_CMD;
      cnt      <= '0;
      sr_in    <= '0;
      addr_q   <= '0;
      dec_q    <= '0;
      pend_v   <= 1'b0;
      pend_bit <= 1'b0;
    end else if (cs_n) begin
      phase  <= PH_CMD;
      cnt    <= '0;
      pend_v <= 1'b0;
      if (cs_rise && pend_v) quad_q <= pend_bit;
    end else begin
      if (load) begin
        if (dec_q.is_id) addr_q <= (addr_q[1:0] == 2'd2) ? '0 : addr_q + 1'b1;
        else             addr_q <= addr_q + 1'b1;
      end
      if (sck_rise) begin
        unique case (phase)
          PH_CMD: begin
            sr_in <= sr_next;
            cnt   <= cnt_next;
            if (cnt_next == CNT_W'(8)) begin
              dec_q <= dec_now;
              cnt   <= '0;
              if (dec_now.is_read)      phase <= PH_ADDR;
              else if (dec_now.is_id) begin
                phase  <= PH_DATA;
                addr_q <= '0;
              end
              else if (dec_now.is_cfg)  phase <= PH_CFG;
              else                      phase <= PH_SKIP;
            end
          end
          PH_ADDR: begin
            sr_in <= sr_next;
            cnt   <= cnt_next;
            if (cnt_next == CNT_W'(ADDR_BITS)) begin
              addr_q <= sr_next[MEM_AW-1:0];
              cnt    <= '0;
              phase  <= dec_q.dummy ? PH_DUMMY : PH_DATA;
            end
          end
          PH_DUMMY: begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(DUMMY_CLKS - 1)) begin
              cnt   <= '0;
              phase <= PH_DATA;
            end
          end
          PH_CFG: begin
            sr_in <= sr_next;
            cnt   <= cnt_next;
            if (cnt_next == CNT_W'(8)) begin
              pend_v   <= 1'b1;
              pend_bit <= sr_next[7];
              phase    <= PH_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign dq_out = drive;
  assign dq_oe  = active ? (dec_q.data_w4 ? 4'b1111 : 4'b0010) : 4'b0000;
endmodule

// File: rtl/flash_mode_responder_chk.sv
module flash_mode_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [3:0] dq_oe,
  input logic [3:0] dq_out,
  input logic       ph_data,
  input logic       quad_q,
  input logic       cs_rise,
  input logic       shift_out
);
  // R10
  oe_only_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != 4'b0000) |-> ph_data);

  // R10
  oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == 4'b0000) || (dq_oe == 4'b0010) || (dq_oe == 4'b1111));

  // R8
  mode_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(quad_q) |-> $past(cs_rise));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> (dq_oe == 4'b0000));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_out |=> $stable(dq_out));
endmodule

bind flash_mode_responder flash_mode_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dq_oe(dq_oe), .dq_out(dq_out),
  .ph_data(ph_data), .quad_q(quad_q), .cs_rise(cs_rise), .shift_out(shift_out)
);

// File: tb/sim_flash_mode_responder.sv
module sim_flash_mode_responder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boot_quad = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic [3:0] dq_in = 4'h0;
  logic [3:0] dq_out, dq_oe;
  logic [3:0] last_out, last_oe;
  int         n_chk = 0, n_bad = 0;
  logic       done = 1'b0;

  always #10 clk = ~clk;

  flash_mode_responder u0 (
    .clk(clk), .rst_n(rst_n), .boot_quad(boot_quad), .cs_n(cs_n),
    .sck(sck), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  typedef struct packed {
    logic        q;
    logic        id;
    logic [7:0]  op;
    logic        aw4;
    logic        dw4;
    logic        dum;
    logic [23:0] a;
    logic [7:0]  e0;
    logic [7:0]  e1;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 8'h03, 1'b0, 1'b0, 1'b0, 24'h000010, 8'h2C, 8'h2D}, // R4
    '{1'b0, 1'b0, 8'h0B, 1'b0, 1'b0, 1'b1, 24'h0000A0, 8'h9C, 8'h9D}, // R5
    '{1'b0, 1'b0, 8'h6B, 1'b0, 1'b1, 1'b1, 24'h000033, 8'h0F, 8'h08}, // R6
    '{1'b0, 1'b0, 8'hEB, 1'b1, 1'b1, 1'b1, 24'h0000F0, 8'hCC, 8'hCD}, // R6
    '{1'b0, 1'b1, 8'h9F, 1'b0, 1'b0, 1'b0, 24'h000000, 8'h5E, 8'h71}, // R2
    '{1'b1, 1'b0, 8'h6B, 1'b1, 1'b1, 1'b1, 24'h000055, 8'h69, 8'h6A}, // R7
    '{1'b1, 1'b0, 8'hEB, 1'b1, 1'b1, 1'b1, 24'h0000FF, 8'hC3, 8'h3C}, // R7 wrap
    '{1'b1, 1'b0, 8'h03, 1'b1, 1'b1, 1'b0, 24'h000001, 8'h3D, 8'h3E}, // R7
    '{1'b1, 1'b1, 8'hAF, 1'b1, 1'b1, 1'b0, 24'h000000, 8'h5E, 8'h71}  // R3
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [3:0] d);
    @(negedge clk) dq_in = d;
    repeat (2) @(negedge clk);
    sck = 1'b1;
    repeat (2) @(negedge clk);
    sck = 1'b0;
    repeat (2) @(negedge clk);
    last_out = dq_out;
    last_oe  = dq_oe;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic w4);
    if (w4) begin
      pulse(b[7:4]);
      pulse(b[3:0]);
    end else begin
      for (int i = 7; i >= 0; i--) pulse({3'b000, b[i]});
    end
  endtask

  task automatic send_addr(input logic [23:0] a, input logic w4);
    if (w4) begin
      for (int i = 5; i >= 0; i--) pulse(a[4*i +: 4]);
    end else begin
      for (int i = 23; i >= 0; i--) pulse({3'b000, a[i]});
    end
  endtask

  task automatic read_byte(input logic w4, output logic [7:0] b);
    if (w4) begin
      b[7:4] = last_out;
      pulse(4'h0);
      b[3:0] = last_out;
      pulse(4'h0);
    end else begin
      for (int i = 7; i >= 0; i--) begin
        b[i] = last_out[1];
        pulse(4'h0);
      end
    end
  endtask

  task automatic cs_on();
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_off();
    @(negedge clk) cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(input logic q);
    @(negedge clk);
    rst_n = 1'b0; boot_quad = q; cs_n = 1'b1; sck = 1'b0; dq_in = 4'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // probe: send an ID opcode and return the first byte and whether any enable rose
  task automatic id_probe(input logic [7:0] op, input logic w4, output logic [7:0] b);
    cs_on();
    send_byte(op, w4);
    if (last_oe == 4'h0) b = 8'hXX;
    else read_byte(w4, b);
    cs_off();
  endtask

  task automatic silent_run(input int n, output logic [3:0] seen);
    seen = 4'h0;
    for (int i = 0; i < n; i++) begin
      pulse(4'hF);
      seen = seen | last_oe;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [3:0] seen;

    // R1 reset state in both boot modes
    do_reset(1'b0);
    check("R1 oe after reset", {4'h0, dq_oe}, 8'h00);

    // table walk
    for (int v = 0; v < NV; v++) begin
      do_reset(VEC[v].q);
      cs_on();
      send_byte(VEC[v].op, VEC[v].q);
      if (!VEC[v].id) begin
        send_addr(VEC[v].a, VEC[v].aw4);
        if (VEC[v].dum) for (int k = 0; k < 8; k++) pulse(4'h0);
      end
      check("R10 data enable mask", {4'h0, last_oe}, VEC[v].dw4 ? 8'h0F : 8'h02);
      read_byte(VEC[v].dw4, b);
      check("R4/R5/R6/R7 vector byte0", b, VEC[v].e0);
      read_byte(VEC[v].dw4, b);
      check("R4/R5/R6/R7 vector byte1", b, VEC[v].e1);
      cs_off();
      check("R10 enable off after deselect", {4'h0, dq_oe}, 8'h00);
    end

    // R1 boot quad: extended ID opcode ignored, quad one answered
    do_reset(1'b1);
    id_probe(8'h9F, 1'b1, b);
    check("R1 boot quad ignores 9F", b, 8'hXX);
    id_probe(8'hAF, 1'b1, b);
    check("R1 boot quad answers AF", b, 8'h5E);

    // R2 ID repeats after third byte
    do_reset(1'b0);
    cs_on();
    send_byte(8'h9F, 1'b0);
    read_byte(1'b0, b);
    read_byte(1'b0, b);
    read_byte(1'b0, b);
    check("R2 third id byte", b, 8'h18);
    read_byte(1'b0, b);
    check("R2 id wraps", b, 8'h5E);
    cs_off();

    // R2 AF ignored in extended mode
    cs_on();
    send_byte(8'hAF, 1'b0);
    silent_run(32, seen);
    check("R2 AF silent in extended", {4'h0, seen}, 8'h00);
    cs_off();

    // R3 9F ignored in quad mode
    do_reset(1'b1);
    cs_on();
    send_byte(8'h9F, 1'b1);
    silent_run(32, seen);
    check("R3 9F silent in quad", {4'h0, seen}, 8'h00);
    cs_off();

    // R9 unknown opcode silent, next transaction normal
    do_reset(1'b0);
    cs_on();
    send_byte(8'h5A, 1'b0);
    silent_run(40, seen);
    check("R9 unknown opcode silent", {4'h0, seen}, 8'h00);
    cs_off();
    id_probe(8'h9F, 1'b0, b);
    check("R9 recovers after deselect", b, 8'h5E);

    // R8 set quad via config byte 0x80
    do_reset(1'b0);
    cs_on();
    send_byte(8'hB1, 1'b0);
    send_byte(8'h80, 1'b0);
    silent_run(8, seen);
    check("R8 config phase silent", {4'h0, seen}, 8'h00);
    cs_off();
    id_probe(8'hAF, 1'b1, b);
    check("R8 quad after config", b, 8'h5E);
    id_probe(8'h9F, 1'b1, b);
    check("R8 9F ignored after config", b, 8'hXX);

    // R8 aborted config byte leaves mode
    do_reset(1'b0);
    cs_on();
    send_byte(8'hB1, 1'b0);
    for (int i = 0; i < 4; i++) pulse(4'h1);
    cs_off();
    id_probe(8'h9F, 1'b0, b);
    check("R8 aborted config keeps extended", b, 8'h5E);

    // R8 only bit 7 matters
    do_reset(1'b0);
    cs_on();
    send_byte(8'hB1, 1'b0);
    send_byte(8'h7F, 1'b0);
    cs_off();
    id_probe(8'h9F, 1'b0, b);
    check("R8 bit7 clear keeps extended", b, 8'h5E);

    // R8 clear quad using four-line config
    do_reset(1'b1);
    cs_on();
    send_byte(8'hB1, 1'b1);
    send_byte(8'h00, 1'b1);
    cs_off();
    id_probe(8'h9F, 1'b0, b);
    check("R8 back to extended", b, 8'h5E);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule